// File: doc/BRIEF.md
# Edge-Timed Pulse Width Capture

This block times a single asynchronous serial data line coming from a radio receiver. The line first passes through a synchroniser. A tick counter then measures it, advancing once per tick of a divided clock, and each detected edge of the line produces one measurement. A falling edge reports how long the line has been high since the last rising edge. A rising edge reports the full period since the previous rising edge, and then restarts the counter from zero. Because the rising edge itself clears the counter, neither measurement needs a subtraction.

Software-side logic or a downstream decoder starts capture with a one-cycle `start` pulse and ends it with a one-cycle `stop` pulse. Measurements appear as single-cycle events that carry a phase bit and a duration in ticks. A request made in the wrong state is ignored and raises an error flag that stays set.

Top module: `pwcap_top`

## Requirements
- R1: While `rst_n` is low, `evt_valid`, `capturing` and `err` are 0.
- R2: A `start` pulse (with `stop` low) while idle sets `capturing` in the next cycle. It also clears the tick counter and the tick divider, so the first measurement counts from that moment.
- R3: While capturing, a rising edge of the synchronised line emits an event with `evt_level` = 0. Its `evt_duration` is the number of ticks since the previous rising edge, or since the accepted start. The counter then restarts at zero, and this holds even when a tick falls in the same cycle as the edge.
- R4: While capturing, a falling edge of the synchronised line emits an event with `evt_level` = 1. Its `evt_duration` is the number of ticks since the last rising edge, or since the accepted start.
- R5: Every edge produces an event, with no prescaling and no filtering. `evt_valid` is high for exactly one cycle per edge, three clock cycles after the cycle in which `din` changed. Edges only two cycles apart still yield two events.
- R6: The counter advances by one every `TICK_DIV` clock cycles of capture.
- R7: When no rising edge arrives, the counter stops at all ones and does not wrap. The next event then reports the all-ones value.
- R8: Three kinds of request are illegal: `start` while capturing, `stop` while idle, and `start` and `stop` in the same cycle. An illegal request leaves the state unchanged and sets `err`, which stays at 1 until reset.
- R9: A `stop` pulse (with `start` low) while capturing clears `capturing` in the next cycle. Edges of `din` in the idle state produce no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Asynchronous serial data line |
| start | input | 1 | Capture start request (one-cycle pulse) |
| stop | input | 1 | Capture stop request (one-cycle pulse) |
| capturing | output | 1 | 1 while capture is running |
| err | output | 1 | Sticky illegal-request flag |
| evt_valid | output | 1 | One-cycle measurement strobe |
| evt_level | output | 1 | 1: high-phase time, 0: full period |
| evt_duration | output | CNT_W | Measured duration in ticks |

## Verification
The bench builds the block with `TICK_DIV` = 3 and `CNT_W` = 8. The short divider lets rising edges land on, just before and just after a tick, and it produces edges that are closer together than one tick. The narrow counter reaches its all-ones limit after about 765 clocks of steady high input, so saturation and the value reported after it fall within a short run.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;

  // saturating increment used by the tick counter
  function automatic logic [63:0] sat_next(input logic [63:0] cur, input logic [63:0] top);
    return (cur >= top) ? top : cur + 64'd1;
  endfunction

endpackage

// File: rtl/pwcap_sync_edge.sv
module pwcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= din;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pwcap_tick.sv
module pwcap_tick #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      logic unused_clr;
      assign unused_clr = clr;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             div_q <= '0;
        else if (clr)           div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pwcap_counter.sv
module pwcap_counter
  import pwcap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             restart,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [63:0] TOP = 64'((65'd1 << CNT_W) - 65'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (restart) cnt <= '0;
    else if (adv)     cnt <= CNT_W'(sat_next(64'(cnt), TOP));
  end
endmodule

// File: rtl/pwcap_top.sv
module pwcap_top
  import pwcap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int TICK_DIV    = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             start,
  input  logic             stop,
  output logic             capturing,
  output logic             err,
  output logic             evt_valid,
  output logic             evt_level,
  output logic [CNT_W-1:0] evt_duration
);
  cap_state_e       state_q;
  logic             rise_w, fall_w, tick_w;
  logic             start_ok, stop_ok, bad_req;
  logic [CNT_W-1:0] cnt_q;

  pwcap_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(din), .rise(rise_w), .fall(fall_w)
  );

  pwcap_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .tick(tick_w)
  );

  pwcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_ok),
    .restart(capturing & rise_w), .adv(capturing & tick_w), .cnt(cnt_q)
  );

  assign capturing = (state_q == CAP_RUN);
  assign start_ok  = start & ~stop & (state_q == CAP_IDLE);
  assign stop_ok   = stop & ~start & (state_q == CAP_RUN);
  assign bad_req   = (start | stop) & ~start_ok & ~stop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      err     <= 1'b0;
    end else begin
      if (start_ok)     state_q <= CAP_RUN;
      else if (stop_ok) state_q <= CAP_IDLE;
      if (bad_req)      err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid    <= 1'b0;
      evt_level    <= 1'b0;
      evt_duration <= '0;
    end else begin
      evt_valid <= capturing & (rise_w | fall_w);
      if (capturing & (rise_w | fall_w)) begin
        evt_level    <= fall_w;
        evt_duration <= cnt_q;
      end
    end
  end
endmodule

// File: rtl/pwcap_chk.sv
module pwcap_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             capturing,
  input logic             err,
  input logic             evt_valid,
  input logic             evt_level,
  input logic [CNT_W-1:0] evt_duration,
  input logic             rise_w,
  input logic             fall_w,
  input logic             start_ok,
  input logic [CNT_W-1:0] cnt_q
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8

  AST_RISE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && rise_w) |=> (cnt_q == '0)); // R3

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && !rise_w && (cnt_q == '1)) |=> (cnt_q == '1)); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && !rise_w && !start_ok) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1))); // R6

  AST_EVT_CONTENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(capturing) && ($past(rise_w) || $past(fall_w))) |->
      (evt_valid && evt_duration == $past(cnt_q) && evt_level == $past(fall_w))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!capturing && !$past(capturing)) |-> !evt_valid); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (capturing && cnt_q == '0)); // R2
endmodule

bind pwcap_top pwcap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .capturing(capturing), .err(err),
  .evt_valid(evt_valid), .evt_level(evt_level), .evt_duration(evt_duration),
  .rise_w(rise_w), .fall_w(fall_w), .start_ok(start_ok), .cnt_q(cnt_q)
);

// File: tb/sim_pwcap_top.sv
`timescale 1ns/1ps
module sim_pwcap_top;
  localparam int CW  = 8;
  localparam int DIV = 3;
  localparam logic [CW-1:0] MAXV = '1;

  logic clk = 1'b0, rst_n = 1'b0, din = 1'b0, start = 1'b0, stop = 1'b0;
  logic capturing, err, evt_valid, evt_level;
  logic [CW-1:0] evt_duration;

  int n_run = 0, n_fail = 0;
  bit run_chk = 1'b0, saw_sat = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  pwcap_top #(.CNT_W(CW), .TICK_DIV(DIV), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .start(start), .stop(stop),
    .capturing(capturing), .err(err), .evt_valid(evt_valid),
    .evt_level(evt_level), .evt_duration(evt_duration)
  );

  // expected behaviour derived from the requirements
  bit m1, m2, m3, m_capt, m_err, e_valid, e_level;
  int m_div, m_cnt, e_dur;

  function automatic int next_count(int c, bit r, bit t, bit run, bit s);
    if (s) return 0;
    if (run && r) return 0;
    if (run && t) return (c >= int'(MAXV)) ? int'(MAXV) : c + 1;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; m_capt = 0; m_err = 0; e_valid = 0;
      e_level = 0; m_div = 0; m_cnt = 0; e_dur = 0;
    end else begin
      bit r, f, t, sok, pok;
      r = m2 && !m3;  f = !m2 && m3;  t = (m_div == DIV - 1);
      sok = start && !stop && !m_capt;
      pok = stop && !start && m_capt;
      e_valid = m_capt && (r || f);
      if (e_valid) begin e_level = f; e_dur = m_cnt; end
      m_cnt = next_count(m_cnt, r, t, m_capt, sok);
      m_div = (sok || t) ? 0 : m_div + 1;
      if ((start || stop) && !sok && !pok) m_err = 1;
      if (sok) m_capt = 1; else if (pok) m_capt = 0;
      m3 = m2; m2 = m1; m1 = din;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      check(evt_valid == e_valid, "R5 evt_valid", int'(evt_valid), int'(e_valid));
      check(capturing == m_capt, "R2 R9 capturing", int'(capturing), int'(m_capt));
      check(err == m_err, "R8 err", int'(err), int'(m_err));
      if (e_valid && evt_valid) begin
        if (e_level) begin
          check(evt_level == 1'b1, "R4 level", int'(evt_level), 1);
          check(int'(evt_duration) == e_dur, "R4 R6 high time", int'(evt_duration), e_dur);
        end else begin
          check(evt_level == 1'b0, "R3 level", int'(evt_level), 0);
          check(int'(evt_duration) == e_dur, "R3 R6 period", int'(evt_duration), e_dur);
        end
        if (e_dur == int'(MAXV)) begin
          saw_sat = 1'b1;
          check(evt_duration == MAXV, "R7 saturated value", int'(evt_duration), int'(MAXV));
        end
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; wait_n(1); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; wait_n(1); stop = 1'b0;
  endtask

  task automatic random_toggles(int n, int maxgap);
    for (int i = 0; i < n; i++) begin
      din = ~din;
      wait_n(1 + int'($urandom_range(maxgap - 1)));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    wait_n(3);
    // R1 reset state
    check(evt_valid == 1'b0, "R1 evt_valid in reset", int'(evt_valid), 0);
    check(capturing == 1'b0, "R1 capturing in reset", int'(capturing), 0);
    check(err == 1'b0, "R1 err in reset", int'(err), 0);
    rst_n = 1'b1;
    run_chk = 1'b1;
    wait_n(2);
    pulse_start();                       // R2
    wait_n(4);
    // directed: a 2-cycle pulse and 1-cycle gaps (R5)
    din = 1; wait_n(2); din = 0; wait_n(1); din = 1; wait_n(1); din = 0; wait_n(8);
    // one rising edge per divider phase (R3)
    for (int ph = 0; ph < DIV; ph++) begin
      din = 1; wait_n(5 + ph); din = 0; wait_n(4);
    end
    random_toggles(200, 12);
    // saturation (R7)
    din = 1; wait_n(DIV * 300); din = 0; wait_n(DIV * 300); din = 1; wait_n(10);
    din = 0; wait_n(6);
    pulse_stop();                        // R9
    random_toggles(30, 6);
    wait_n(6);
    pulse_stop();                        // R8 stop while idle
    wait_n(3);
    pulse_start();
    wait_n(3);
    pulse_start();                       // R8 start while capturing
    start = 1'b1; stop = 1'b1; wait_n(1); start = 1'b0; stop = 1'b0;   // R8 both
    random_toggles(300, 20);
    random_toggles(200, 3);
    wait_n(8);
    run_chk = 1'b0;
    check(saw_sat, "R7 saturated event observed", int'(saw_sat), 1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule